// File: doc/BRIEF.md
# Sleep Entry and Wakeup Controller

This block moves a chip from its running state into light or deep sleep and back. Software first presents three masks: a set of power domains to switch off, a set of wakeup sources that may end the sleep, and a set of sources that forbid entry. It then pulses a start request. If a forbidding source is already active, the block refuses, raises a reject flag and keeps running. Otherwise it isolates the chosen domains and removes their power a cycle later. It waits out a minimum sleep time, then watches the enabled sources.

When an enabled source fires, the block latches which sources caused the wake. It lets a fixed wakeup delay pass, then restores the domains one at a time in ascending index order. Each restored domain gets its own power-up delay and wait delay before its isolation is lifted. When domain bit 0 (the digital domain) was among those switched off, the sleep counts as deep. In deep sleep a group of sources is masked out, and on exit a one-cycle CPU reset request is issued. After a light sleep the block simply returns to the running state.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset every domain is powered, no domain is isolated, the cause register is zero, and neither the reject flag nor the CPU reset request is high.
- R2: A start request taken while a source is high in both the source vector and the reject-enable mask sets the reject flag one cycle later. Power and isolation outputs are left unchanged and the block stays in the running state.
- R3: For an accepted start, bit i of the domain mask selects domain i. The isolation of every selected domain rises one cycle after the start is sampled, and its power enable falls one cycle after that.
- R4: Wakeup sources are not examined until 2 cycles after power was removed. A source held high from the start request is latched 3 cycles after power removal.
- R5: The cause register is loaded with the AND of the source vector and the armed wakeup mask in the cycle the wake is taken. Source bit 3 is the timer and bit 4 is SDIO.
- R6: In deep sleep, source bits 2, 4, 5, 6, 7 and 10 are removed from the wakeup mask and cannot wake the chip or appear in the cause register.
- R7: The first restored domain k (the lowest selected index) regains power 5 + k cycles after the cause is latched. This includes a 4-cycle wakeup delay and one cycle per skipped lower index.
- R8: Domains are restored in ascending index order. For each one, isolation is released max(P,1) + max(W,1) cycles after its power enable rises, where P is its 7-bit power-up delay and W is its 9-bit wait delay. Isolation is never released while a domain is unpowered.
- R9: One cycle after the last domain is handled, the CPU reset request is high for exactly one cycle if the sleep was deep, and stays low after a light sleep.
- R10: A start request arriving while the block is not in the running state has no effect on the ongoing sequence.
- R11: The cause register holds its value until the clear input is pulsed. A wake latch in the same cycle as a clear wins.
- R12: An accepted start request clears a previously set reject flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; all delays count its cycles |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle sleep entry request |
| slp_pd_i | input | NUM_DOM | Domains to switch off; bit 0 marks deep sleep |
| wake_en_i | input | NUM_SRC | Sources allowed to end the sleep |
| rej_en_i | input | NUM_SRC | Sources that forbid sleep entry |
| src_i | input | NUM_SRC | Wakeup source levels |
| pu_dly_i | input | NUM_DOM*PU_W | Per-domain power-up delay, domain i at bits [i*PU_W +: PU_W] |
| wt_dly_i | input | NUM_DOM*WT_W | Per-domain wait delay, domain i at bits [i*WT_W +: WT_W] |
| cause_clr_i | input | 1 | Clears the cause register |
| pwr_en_o | output | NUM_DOM | Per-domain power enable |
| iso_o | output | NUM_DOM | Per-domain isolation |
| cause_o | output | NUM_SRC | Latched wakeup cause |
| reject_o | output | 1 | Last start request was refused |
| cpu_rst_o | output | 1 | One-cycle CPU reset request after deep sleep |

## Verification
Clearing the cause register and latching a new wakeup cause can happen in the same cycle. The bench sets up this collision during a deep sleep: a cause from the earlier light sleep is still held, and the clear pulse and the enabled timer source are raised at the same falling edge. The result is judged correct only if the cause register then shows the timer bit alone. That means the old cause is gone and the clear had no further effect. A second overlap is also exercised. A start request arrives during the wakeup delay of a light sleep, and every later power and isolation edge must keep its predicted cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_ISO    = 3'd1,
        ST_OFF    = 3'd2,
        ST_SLEEP  = 3'd3,
        ST_WDLY   = 3'd4,
        ST_PWRUP  = 3'd5,
        ST_FINISH = 3'd6
    } slp_state_e;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_PU    = 2'd1,
        PH_WT    = 2'd2
    } slp_phase_e;

endpackage

// File: rtl/slp_wake_eval.sv
module slp_wake_eval #(
    parameter int                  NUM_SRC    = 15,
    parameter logic [NUM_SRC-1:0]  LIGHT_ONLY = 15'h04F4
) (
    input  logic [NUM_SRC-1:0] wake_en_i,
    input  logic [NUM_SRC-1:0] rej_en_i,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               deep_i,
    input  logic [NUM_SRC-1:0] armed_mask_i,
    output logic [NUM_SRC-1:0] eff_mask_o,
    output logic               rej_hit_o,
    output logic [NUM_SRC-1:0] wake_vec_o,
    output logic               wake_hit_o
);

    // Mask applied for the coming sleep: deep sleep drops light-only sources.
    always_comb begin
        eff_mask_o = deep_i ? (wake_en_i & ~LIGHT_ONLY) : wake_en_i;
        rej_hit_o  = |(src_i & rej_en_i);
        wake_vec_o = src_i & armed_mask_i;
        wake_hit_o = |wake_vec_o;
    end

endmodule

// File: rtl/slp_dly_pick.sv
module slp_dly_pick #(
    parameter int NUM_DOM = 12,
    parameter int PU_W    = 7,
    parameter int WT_W    = 9,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_DOM*PU_W-1:0] pu_flat_i,
    input  logic [NUM_DOM*WT_W-1:0] wt_flat_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [PU_W-1:0]         pu_o,
    output logic [WT_W-1:0]         wt_o
);

    logic [PU_W-1:0] pu_arr [NUM_DOM];
    logic [WT_W-1:0] wt_arr [NUM_DOM];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_unpack
        assign pu_arr[g] = pu_flat_i[g*PU_W +: PU_W];
        assign wt_arr[g] = wt_flat_i[g*WT_W +: WT_W];
    end

    always_comb begin
        pu_o = '0;
        wt_o = '0;
        if (int'(idx_i) < NUM_DOM) begin
            pu_o = pu_arr[idx_i];
            wt_o = wt_arr[idx_i];
        end
    end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
    parameter int                 NUM_SRC    = 15,
    parameter int                 NUM_DOM    = 12,
    parameter int                 PU_W       = 7,
    parameter int                 WT_W       = 9,
    parameter int                 MIN_SLP    = 2,
    parameter int                 WAKE_DLY   = 4,
    parameter int                 DEEP_BIT   = 0,
    parameter logic [NUM_SRC-1:0] LIGHT_ONLY = 15'h04F4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NUM_DOM-1:0]      slp_pd_i,
    input  logic [NUM_SRC-1:0]      wake_en_i,
    input  logic [NUM_SRC-1:0]      rej_en_i,
    input  logic [NUM_SRC-1:0]      src_i,
    input  logic [NUM_DOM*PU_W-1:0] pu_dly_i,
    input  logic [NUM_DOM*WT_W-1:0] wt_dly_i,
    input  logic                    cause_clr_i,
    output logic [NUM_DOM-1:0]      pwr_en_o,
    output logic [NUM_DOM-1:0]      iso_o,
    output logic [NUM_SRC-1:0]      cause_o,
    output logic                    reject_o,
    output logic                    cpu_rst_o
);
    import slp_pkg::*;

    localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int CNT_W = (WT_W > PU_W) ? WT_W : PU_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DOM - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        slp_state_e         st;
        slp_phase_e         ph;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [NUM_DOM-1:0] pd;
        logic               deep;
        logic [NUM_SRC-1:0] wmask;
        logic [NUM_DOM-1:0] pwr;
        logic [NUM_DOM-1:0] iso;
        logic [NUM_SRC-1:0] cause;
        logic               rej;
        logic               rst;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [NUM_SRC-1:0] eff_mask;
    logic               rej_hit;
    logic [NUM_SRC-1:0] wake_vec;
    logic               wake_hit;
    logic [PU_W-1:0]    pu_sel;
    logic [WT_W-1:0]    wt_sel;
    logic               adv;

    slp_wake_eval #(
        .NUM_SRC    (NUM_SRC),
        .LIGHT_ONLY (LIGHT_ONLY)
    ) u_eval (
        .wake_en_i    (wake_en_i),
        .rej_en_i     (rej_en_i),
        .src_i        (src_i),
        .deep_i       (slp_pd_i[DEEP_BIT]),
        .armed_mask_i (r_q.wmask),
        .eff_mask_o   (eff_mask),
        .rej_hit_o    (rej_hit),
        .wake_vec_o   (wake_vec),
        .wake_hit_o   (wake_hit)
    );

    slp_dly_pick #(
        .NUM_DOM (NUM_DOM),
        .PU_W    (PU_W),
        .WT_W    (WT_W),
        .IDX_W   (IDX_W)
    ) u_dly (
        .pu_flat_i (pu_dly_i),
        .wt_flat_i (wt_dly_i),
        .idx_i     (r_q.idx),
        .pu_o      (pu_sel),
        .wt_o      (wt_sel)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rst = 1'b0;
        adv     = 1'b0;
        if (cause_clr_i) begin
            r_d.cause = '0;
        end
        case (r_q.st)
            ST_ACTIVE: begin
                if (start_i) begin
                    if (rej_hit) begin
                        r_d.rej = 1'b1;
                    end else begin
                        r_d.rej   = 1'b0;
                        r_d.pd    = slp_pd_i;
                        r_d.deep  = slp_pd_i[DEEP_BIT];
                        r_d.wmask = eff_mask;
                        r_d.iso   = r_q.iso | slp_pd_i;
                        r_d.st    = ST_ISO;
                    end
                end
            end
            ST_ISO: begin
                r_d.pwr = r_q.pwr & ~r_q.pd;
                r_d.cnt = CNT_W'(MIN_SLP);
                r_d.st  = ST_OFF;
            end
            ST_OFF: begin
                if (r_q.cnt <= CNT_ONE) begin
                    r_d.st = ST_SLEEP;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            ST_SLEEP: begin
                if (wake_hit) begin
                    r_d.cause = wake_vec;
                    r_d.cnt   = CNT_W'(WAKE_DLY);
                    r_d.st    = ST_WDLY;
                end
            end
            ST_WDLY: begin
                if (r_q.cnt <= CNT_ONE) begin
                    r_d.st  = ST_PWRUP;
                    r_d.idx = '0;
                    r_d.ph  = PH_START;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            ST_PWRUP: begin
                case (r_q.ph)
                    PH_START: begin
                        if (r_q.pd[r_q.idx]) begin
                            r_d.pwr[r_q.idx] = 1'b1;
                            r_d.cnt          = CNT_W'(pu_sel);
                            r_d.ph           = PH_PU;
                        end else begin
                            adv = 1'b1;
                        end
                    end
                    PH_PU: begin
                        if (r_q.cnt <= CNT_ONE) begin
                            r_d.cnt = CNT_W'(wt_sel);
                            r_d.ph  = PH_WT;
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_ONE;
                        end
                    end
                    PH_WT: begin
                        if (r_q.cnt <= CNT_ONE) begin
                            r_d.iso[r_q.idx] = 1'b0;
                            adv              = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt - CNT_ONE;
                        end
                    end
                    default: r_d.ph = PH_START;
                endcase
                if (adv) begin
                    r_d.ph = PH_START;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                r_d.rst = r_q.deep;
                r_d.st  = ST_ACTIVE;
            end
            default: r_d.st = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.pwr <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_en_o  = r_q.pwr;
    assign iso_o     = r_q.iso;
    assign cause_o   = r_q.cause;
    assign reject_o  = r_q.rej;
    assign cpu_rst_o = r_q.rst;

    // R3: a domain loses power only after a cycle already isolated
    p_iso_before_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(r_q.pwr) & ~r_q.pwr) & ~$past(r_q.iso)) == '0));

    // R8: no unpowered domain is ever left without isolation
    p_no_open_unpowered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pwr_en_o & ~iso_o) == '0));

    // R9: the reset request never lasts more than one cycle
    p_rst_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_o |=> !cpu_rst_o);

    // R2: a refusal leaves power and isolation untouched
    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reject_o) |-> ($stable(pwr_en_o) && $stable(iso_o)));

    // R5: a newly latched cause lies inside the armed mask
    p_cause_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r_q.cause) && (r_q.cause != '0)) |-> ((r_q.cause & ~r_q.wmask) == '0));

    // R6: deep sleep never latches a light-only source
    p_deep_no_light_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r_q.cause) && r_q.deep && (r_q.cause != '0)) |-> ((r_q.cause & LIGHT_ONLY) == '0));

    // R10: configuration is frozen whenever the block is away from the running state
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_ACTIVE) |=> $stable(r_q.pd));

endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
    localparam int NS = 15;
    localparam int ND = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              start;
    logic [ND-1:0]     pd;
    logic [NS-1:0]     wen, ren, src;
    logic [ND*7-1:0]   pu_dly;
    logic [ND*9-1:0]   wt_dly;
    logic              cclr;
    logic [ND-1:0]     pwr, iso;
    logic [NS-1:0]     cause;
    logic              rej, crst;

    sleep_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .slp_pd_i(pd),
        .wake_en_i(wen), .rej_en_i(ren), .src_i(src),
        .pu_dly_i(pu_dly), .wt_dly_i(wt_dly), .cause_clr_i(cclr),
        .pwr_en_o(pwr), .iso_o(iso), .cause_o(cause),
        .reject_o(rej), .cpu_rst_o(crst)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        logic [ND-1:0] pwr;
        logic [ND-1:0] iso;
        logic [NS-1:0] cause;
        logic          rej;
        logic          rst;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [ND-1:0] m_pwr = '1;
    logic [ND-1:0] m_iso = '0;
    logic [NS-1:0] m_cause = '0;
    logic          m_rej = 1'b0;
    logic          m_rst = 1'b0;

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at = at; e.pwr = m_pwr; e.iso = m_iso; e.cause = m_cause;
        e.rej = m_rej; e.rst = m_rst; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare every expected snapshot due by this cycle
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            total++;
            if (e.at != cyc || pwr !== e.pwr || iso !== e.iso || cause !== e.cause
                || rej !== e.rej || crst !== e.rst) begin
                bad++;
                $display("FAIL %s cyc=%0d: got pwr=%h iso=%h cause=%h rej=%b rst=%b, expected pwr=%h iso=%h cause=%h rej=%b rst=%b (due %0d)",
                         e.tag, cyc, pwr, iso, cause, rej, crst,
                         e.pwr, e.iso, e.cause, e.rej, e.rst, e.at);
            end
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic int pu_of(input int k);
        return (k % 3 == 0) ? 1 : (k % 3);
    endfunction

    function automatic int wt_of(input int k);
        return (((k * 5) % 4) == 0) ? 1 : ((k * 5) % 4);
    endfunction

    // Predict the restore sequence from the cycle the cause becomes visible
    task automatic plan_wake(input int w, input logic [ND-1:0] sel,
                             input logic deep, output int t_end);
        int  t = w + 4;
        bit  first = 1;
        for (int k = 0; k < ND; k++) begin
            if (sel[k]) begin
                int rise = t + 1;
                int fall = rise + pu_of(k) + wt_of(k);
                m_pwr[k] = 1'b1;
                push(rise, first ? "R7 first domain power-up" : "R8 power-up order");
                first = 0;
                push(fall - 1, "R8 isolation still held");
                m_iso[k] = 1'b0;
                push(fall, "R8 isolation released");
                t = fall;
            end else begin
                t = t + 1;
            end
        end
        t_end = t;
        m_rst = deep;
        push(t_end + 1, deep ? "R9 deep exit reset" : "R9 light exit no reset");
        m_rst = 1'b0;
        push(t_end + 2, "R9 reset request single cycle");
    endtask

    initial begin
        int s, te;
        start = 0; pd = '0; wen = '0; ren = '0; src = '0; cclr = 0;
        for (int k = 0; k < ND; k++) begin
            pu_dly[k*7 +: 7] = 7'(k % 3);
            wt_dly[k*9 +: 9] = 9'((k * 5) % 4);
        end
        push(4, "R1 reset state");
        wait_to(3);
        rst_n = 1'b1;

        // Light sleep woken by SDIO (bit 4), timer (bit 3) enabled but idle
        s = 10;
        wait_to(s);
        pd = 12'h20A; wen = 15'h0018; ren = 15'h0001; src = 15'h0010; start = 1;
        m_iso = m_iso | 12'h20A;
        push(s + 1, "R3 isolation first");
        m_pwr = m_pwr & ~12'h20A;
        push(s + 2, "R3 power removed");
        push(s + 4, "R4 minimum sleep holds off wake");
        m_cause = 15'h0010;
        push(s + 5, "R5 cause latched");
        plan_wake(s + 5, 12'h20A, 1'b0, te);
        push(te + 3, "R11 cause kept after exit");
        wait_to(s + 1); start = 0;
        wait_to(s + 6); start = 1; pd = '1;        // R10 stray start during wake delay
        wait_to(s + 7); start = 0;
        wait_to(te + 2); src = '0;

        // Refused entry: bit 0 is reject-enabled and active
        s = te + 5;
        wait_to(s);
        pd = 12'h00F; ren = 15'h0001; src = 15'h0001; start = 1;
        m_rej = 1'b1;
        push(s + 1, "R2 entry refused");
        push(s + 3, "R2 still running");
        wait_to(s + 1); start = 0;
        wait_to(s + 2); src = '0;

        // Deep sleep: GPIO (bit 2) ignored, timer (bit 3) wakes, clear collides
        s = s + 6;
        wait_to(s);
        pd = 12'h821; wen = 15'h000C; ren = 15'h0001; src = 15'h0004; start = 1;
        m_rej = 1'b0;
        m_iso = m_iso | 12'h821;
        push(s + 1, "R12 reject cleared by accepted start");
        m_pwr = m_pwr & ~12'h821;
        push(s + 2, "R3 deep power removed");
        push(s + 8, "R6 light-only source ignored in deep sleep");
        m_cause = 15'h0008;
        push(s + 9, "R11 latch wins over clear");
        plan_wake(s + 9, 12'h821, 1'b1, te);
        m_cause = '0;
        push(te + 4, "R11 clear empties cause");
        wait_to(s + 1); start = 0;
        wait_to(s + 8); src = 15'h000C; cclr = 1;
        wait_to(s + 9); cclr = 0;
        wait_to(te + 2); src = '0;
        wait_to(te + 3); cclr = 1;
        wait_to(te + 4); cclr = 0;
        wait_to(te + 6);

        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R1 scoreboard: %0d items never compared, expected 0", sb.size());
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R9 watchdog: run did not end, got cycle %0d expected completion", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule